// File: doc/BRIEF.md
# Instruction Dispatch Router

This block sits between register renaming and the out-of-order back end. Each cycle it receives a group of up to `N` renamed instructions. The group arrives in slot order, and a count gives how many of the slots are occupied. The router walks the occupied slots from slot 0 upward and sends each instruction to its destination:

- a plain instruction-queue insert;
- a load reservation in the load/store queue;
- a store reservation in the load/store queue;
- the separate port for non-speculative instructions;
- immediate completion, for a nop.

The queue storage is not part of the block. It is represented only by a free-entry count on an input. The router reduces that count slot by slot within the cycle, so an earlier slot can exhaust the space seen by a later one.

When a slot that is not squashed finds no free entry, the router stops the group at that slot. It raises a block request and a stall toward rename, and it handles no later slots in that cycle. Squashed instructions are dropped and take no entry. Six event counters record:

- squashed drops;
- queue-full stops;
- loads;
- stores;
- non-speculative inserts;
- ordinary dispatches.

All routing outputs are combinational from the current inputs. Only the counters are registered.

Top module: `dispatch_router`

## Requirements
- R1: A synchronous active-low reset clears all six counters to zero. They stay at zero for as long as reset is held.
- R2: A squashed slot produces no strobe or completion flag and takes no queue entry. It adds one to the squash counter, even when the queue is full.
- R3: If the running free count is zero when a non-squashed slot is reached, `block_req` and `rename_stall` are 1. That slot and all higher slots produce no output. The full counter rises by exactly one that cycle.
- R4: A load asserts `lsq_ld_wr` and `iq_wr` for its slot, takes one entry, and adds one to the load counter and to the dispatch counter.
- R5: A store asserts `lsq_st_wr` and `iq_wr` for its slot, takes one entry, and adds one to the store counter and to the dispatch counter.
- R6: A non-speculative instruction asserts `ns_wr` and `commit_rdy` for its slot and does not assert `iq_wr`. It takes one entry and adds one to the non-speculative counter.
- R7: A nop asserts `nop_done` and `commit_rdy` for its slot, takes no entry, and changes no counter.
- R8: The class tests run in this order: squashed, then queue full, then load, then store, then non-speculative, then nop. The first test that matches decides the route. An instruction with no class flag set is a plain instruction queue insert.
- R9: Each slot sees the free count from `iq_free` minus the entries taken by lower slots in the same cycle. At most `iq_free` entries are taken per cycle.
- R10: Slots at index `grp_size` and above produce no output and change no counter, whatever their flags.
- R11: The dispatch counter counts plain, load and store instructions only.
- R12: Slot i of `out_tag` carries that slot's input tag when the slot asserts `iq_wr`, `ns_wr` or `nop_done`. Otherwise it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_size | input | GW | Number of occupied slots, from 0 to N |
| in_squash | input | N | Squashed flag, one bit per slot |
| in_load | input | N | Load flag, one bit per slot |
| in_store | input | N | Store flag, one bit per slot |
| in_nonspec | input | N | Non-speculative flag, one bit per slot |
| in_nop | input | N | Nop flag, one bit per slot |
| in_tag | input | N*TAG_W | Instruction tag; slot i is at bits [i*TAG_W +: TAG_W] |
| iq_free | input | FREE_W | Free instruction-queue entries at the start of the cycle |
| iq_wr | output | N | Instruction-queue insert strobe, one bit per slot |
| lsq_ld_wr | output | N | Load reservation strobe, one bit per slot |
| lsq_st_wr | output | N | Store reservation strobe, one bit per slot |
| ns_wr | output | N | Non-speculative insert strobe, one bit per slot |
| nop_done | output | N | Nop marked issued and executed; queue tail advanced |
| commit_rdy | output | N | Instruction marked ready to commit |
| out_tag | output | N*TAG_W | Tag of each routed slot, or zero |
| block_req | output | 1 | Group stopped on a full queue |
| rename_stall | output | 1 | Stall request toward rename |
| cnt_squash | output | CNT_W | Squashed-drop counter |
| cnt_iq_full | output | CNT_W | Queue-full stop counter |
| cnt_load | output | CNT_W | Load counter |
| cnt_store | output | CNT_W | Store counter |
| cnt_nonspec | output | CNT_W | Non-speculative counter |
| cnt_disp | output | CNT_W | Ordinary dispatch counter |

## Verification
The assertions assume two things about the inputs. First, `grp_size` never exceeds `N`. Second, `iq_free` is a true count of free entries, so a queue with k entries free can accept at most k entries. The bench satisfies both by sweeping `grp_size` only from 0 to N and `iq_free` only from 0 to N.

Every slot takes one of eight flag patterns. These include a squashed load and two patterns with several class flags set at once, which test the priority order. The patterns are swept in all combinations across four slots, against every group size and free count. The expected routing and counter totals are worked out arithmetically in the bench.

// File: rtl/dispatch_pkg.sv
// Shared types for the dispatch router.
// Assumes nothing beyond the parameters of the top module.
package dispatch_pkg;

    // Class of one slot, after the class-priority decode (full check excluded)
    typedef enum logic [2:0] {
        CL_PLAIN   = 3'd0,
        CL_SQUASH  = 3'd1,
        CL_LOAD    = 3'd2,
        CL_STORE   = 3'd3,
        CL_NONSPEC = 3'd4,
        CL_NOP     = 3'd5
    } slot_cls_e;

    // Counter indices
    localparam int CI_SQUASH  = 0;
    localparam int CI_FULL    = 1;
    localparam int CI_LOAD    = 2;
    localparam int CI_STORE   = 3;
    localparam int CI_NONSPEC = 4;
    localparam int CI_DISP    = 5;
    localparam int NUM_CNT    = 6;

endpackage

// File: rtl/dispatch_slot_class.sv
// Per-slot class decode for the dispatch router.
// Applies the fixed priority squash > load > store > nonspec > nop > plain.
// Does not look at queue space; the top applies the full check after squash.
module dispatch_slot_class
    import dispatch_pkg::*;
(
    input  logic      squash,
    input  logic      load,
    input  logic      store,
    input  logic      nonspec,
    input  logic      nop,
    output slot_cls_e cls
);

    // Priority decode of the class flags
    always_comb begin
        if (squash)       cls = CL_SQUASH;
        else if (load)    cls = CL_LOAD;
        else if (store)   cls = CL_STORE;
        else if (nonspec) cls = CL_NONSPEC;
        else if (nop)     cls = CL_NOP;
        else              cls = CL_PLAIN;
    end

endmodule

// File: rtl/dispatch_evt_counter.sv
// Wrapping event counter: adds a small per-cycle increment.
// Assumes the increment fits in IW bits; synchronous active-low reset.
module dispatch_evt_counter #(
    parameter int CNT_W = 16,
    parameter int IW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    inc,
    output logic [CNT_W-1:0] cnt
);

    // Accumulate the increment every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + CNT_W'(inc);
    end

    AST_CNT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cnt == '0)); // R1

endmodule

// File: rtl/dispatch_router.sv
// Dispatch router: walks up to N renamed instructions in slot order and
// routes each to the instruction queue, a load/store queue reservation,
// the non-speculative port, or immediate nop completion.
// Assumes grp_size <= N and iq_free is the current free-entry count.
// Routing is combinational; only the event counters are registered.
module dispatch_router
    import dispatch_pkg::*;
#(
    parameter int N      = 4,
    parameter int TAG_W  = 4,
    parameter int FREE_W = 4,
    parameter int CNT_W  = 16,
    localparam int GW    = $clog2(N + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GW-1:0]      grp_size,
    input  logic [N-1:0]       in_squash,
    input  logic [N-1:0]       in_load,
    input  logic [N-1:0]       in_store,
    input  logic [N-1:0]       in_nonspec,
    input  logic [N-1:0]       in_nop,
    input  logic [N*TAG_W-1:0] in_tag,
    input  logic [FREE_W-1:0]  iq_free,
    output logic [N-1:0]       iq_wr,
    output logic [N-1:0]       lsq_ld_wr,
    output logic [N-1:0]       lsq_st_wr,
    output logic [N-1:0]       ns_wr,
    output logic [N-1:0]       nop_done,
    output logic [N-1:0]       commit_rdy,
    output logic [N*TAG_W-1:0] out_tag,
    output logic               block_req,
    output logic               rename_stall,
    output logic [CNT_W-1:0]   cnt_squash,
    output logic [CNT_W-1:0]   cnt_iq_full,
    output logic [CNT_W-1:0]   cnt_load,
    output logic [CNT_W-1:0]   cnt_store,
    output logic [CNT_W-1:0]   cnt_nonspec,
    output logic [CNT_W-1:0]   cnt_disp
);

    slot_cls_e         cls [N];
    logic [FREE_W-1:0] avail;
    logic              halt;
    logic [GW-1:0]     inc [NUM_CNT];
    logic [CNT_W-1:0]  cnt [NUM_CNT];

    // One class decoder per slot
    for (genvar g = 0; g < N; g++) begin : g_cls
        dispatch_slot_class u_cls (
            .squash  (in_squash[g]),
            .load    (in_load[g]),
            .store   (in_store[g]),
            .nonspec (in_nonspec[g]),
            .nop     (in_nop[g]),
            .cls     (cls[g])
        );
    end

    // Slot walk: apply the full check in order and route each live slot
    always_comb begin
        avail      = iq_free;
        halt       = 1'b0;
        iq_wr      = '0;
        lsq_ld_wr  = '0;
        lsq_st_wr  = '0;
        ns_wr      = '0;
        nop_done   = '0;
        commit_rdy = '0;
        block_req  = 1'b0;
        for (int k = 0; k < NUM_CNT; k++) inc[k] = '0;
        for (int i = 0; i < N; i++) begin
            if ((GW'(i) < grp_size) && !halt) begin
                if (cls[i] == CL_SQUASH) begin
                    inc[CI_SQUASH] = inc[CI_SQUASH] + GW'(1);
                end else if (avail == '0) begin
                    block_req    = 1'b1;
                    halt         = 1'b1;
                    inc[CI_FULL] = GW'(1);
                end else begin
                    unique case (cls[i])
                        CL_LOAD: begin
                            iq_wr[i]     = 1'b1;
                            lsq_ld_wr[i] = 1'b1;
                            avail        = avail - FREE_W'(1);
                            inc[CI_LOAD] = inc[CI_LOAD] + GW'(1);
                            inc[CI_DISP] = inc[CI_DISP] + GW'(1);
                        end
                        CL_STORE: begin
                            iq_wr[i]      = 1'b1;
                            lsq_st_wr[i]  = 1'b1;
                            avail         = avail - FREE_W'(1);
                            inc[CI_STORE] = inc[CI_STORE] + GW'(1);
                            inc[CI_DISP]  = inc[CI_DISP] + GW'(1);
                        end
                        CL_NONSPEC: begin
                            ns_wr[i]        = 1'b1;
                            commit_rdy[i]   = 1'b1;
                            avail           = avail - FREE_W'(1);
                            inc[CI_NONSPEC] = inc[CI_NONSPEC] + GW'(1);
                        end
                        CL_NOP: begin
                            nop_done[i]   = 1'b1;
                            commit_rdy[i] = 1'b1;
                        end
                        default: begin
                            iq_wr[i]     = 1'b1;
                            avail        = avail - FREE_W'(1);
                            inc[CI_DISP] = inc[CI_DISP] + GW'(1);
                        end
                    endcase
                end
            end
        end
    end

    assign rename_stall = block_req;

    // Tag passthrough for slots that produced any output
    always_comb begin
        for (int i = 0; i < N; i++) begin
            out_tag[i*TAG_W +: TAG_W] = (iq_wr[i] | ns_wr[i] | nop_done[i])
                                      ? in_tag[i*TAG_W +: TAG_W] : '0;
        end
    end

    // Event counters
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        dispatch_evt_counter #(.CNT_W(CNT_W), .IW(GW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[k]),
            .cnt   (cnt[k])
        );
    end

    assign cnt_squash  = cnt[CI_SQUASH];
    assign cnt_iq_full = cnt[CI_FULL];
    assign cnt_load    = cnt[CI_LOAD];
    assign cnt_store   = cnt[CI_STORE];
    assign cnt_nonspec = cnt[CI_NONSPEC];
    assign cnt_disp    = cnt[CI_DISP];

    // Checks on the routing outputs
    for (genvar g = 0; g < N; g++) begin : g_ast
        AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({lsq_ld_wr[g], lsq_st_wr[g], ns_wr[g], nop_done[g]})); // R8
    end

    AST_LDST_IN_IQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((lsq_ld_wr | lsq_st_wr) & ~iq_wr) == '0); // R4

    AST_NOP_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (nop_done & (iq_wr | ns_wr)) == '0); // R7

    AST_ENTRY_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(iq_wr | ns_wr) <= int'(iq_free)); // R9

    AST_BLOCK_EXHAUST: assert property (@(posedge clk) disable iff (!rst_n)
        block_req |-> ($countones(iq_wr | ns_wr) == int'(iq_free))); // R3

    AST_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        block_req |=> (cnt_iq_full == $past(cnt_iq_full) + CNT_W'(1))); // R3

    AST_GROUP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((iq_wr | ns_wr | nop_done) >> grp_size) == '0); // R10

endmodule

// File: tb/test_dispatch_router.sv
// Near-exhaustive sweep: 8 flag patterns per slot over 4 slots, all group
// sizes 0..4 and free counts 0..4, with an arithmetic reference model.
module test_dispatch_router;

    localparam int N      = 4;
    localparam int TAG_W  = 4;
    localparam int FREE_W = 4;
    localparam int CNT_W  = 16;
    localparam int GW     = 3;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [GW-1:0]      grp_size;
    logic [N-1:0]       in_squash, in_load, in_store, in_nonspec, in_nop;
    logic [N*TAG_W-1:0] in_tag;
    logic [FREE_W-1:0]  iq_free;
    logic [N-1:0]       iq_wr, lsq_ld_wr, lsq_st_wr, ns_wr, nop_done, commit_rdy;
    logic [N*TAG_W-1:0] out_tag;
    logic               block_req, rename_stall;
    logic [CNT_W-1:0]   cnt_squash, cnt_iq_full, cnt_load, cnt_store, cnt_nonspec, cnt_disp;

    int n_chk  = 0;
    int n_fail = 0;

    logic [CNT_W-1:0] e_sq = '0, e_full = '0, e_ld = '0, e_st = '0, e_ns = '0, e_disp = '0;

    dispatch_router #(.N(N), .TAG_W(TAG_W), .FREE_W(FREE_W), .CNT_W(CNT_W)) i_dispatch_router (
        .clk(clk), .rst_n(rst_n), .grp_size(grp_size),
        .in_squash(in_squash), .in_load(in_load), .in_store(in_store),
        .in_nonspec(in_nonspec), .in_nop(in_nop), .in_tag(in_tag), .iq_free(iq_free),
        .iq_wr(iq_wr), .lsq_ld_wr(lsq_ld_wr), .lsq_st_wr(lsq_st_wr), .ns_wr(ns_wr),
        .nop_done(nop_done), .commit_rdy(commit_rdy), .out_tag(out_tag),
        .block_req(block_req), .rename_stall(rename_stall),
        .cnt_squash(cnt_squash), .cnt_iq_full(cnt_iq_full), .cnt_load(cnt_load),
        .cnt_store(cnt_store), .cnt_nonspec(cnt_nonspec), .cnt_disp(cnt_disp)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_counters(input string req);
        chk(req, "cnt_squash",  64'(cnt_squash),  64'(e_sq));
        chk(req, "cnt_iq_full", 64'(cnt_iq_full), 64'(e_full));
        chk(req, "cnt_load",    64'(cnt_load),    64'(e_ld));
        chk(req, "cnt_store",   64'(cnt_store),   64'(e_st));
        chk(req, "cnt_nonspec", 64'(cnt_nonspec), 64'(e_ns));
        chk(req, "cnt_disp",    64'(cnt_disp),    64'(e_disp));
    endtask

    // Watchdog: an expired run counts as one failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; grp_size = '0; iq_free = '0; in_tag = '0;
        in_squash = '0; in_load = '0; in_store = '0; in_nonspec = '0; in_nop = '0;
        repeat (3) @(posedge clk);
        #1;
        chk_counters("R1");
        @(negedge clk);
        rst_n = 1'b1;
        for (int code = 0; code < 4096; code++) begin
            for (int grp = 0; grp <= N; grp++) begin
                for (int fr = 0; fr <= N; fr++) begin
                    logic [N-1:0] x_iq, x_ld, x_st, x_ns, x_nop, x_cr;
                    logic [N*TAG_W-1:0] x_tag;
                    logic x_blk, stop;
                    int avail;
                    @(negedge clk);
                    grp_size = GW'(grp);
                    iq_free  = FREE_W'(fr);
                    for (int i = 0; i < N; i++) begin
                        int c;
                        c = (code >> (3 * i)) & 7;
                        // 0 plain, 1 squashed load, 2 load, 3 store, 4 nonspec,
                        // 5 nop, 6 all four classes, 7 nonspec+nop
                        in_squash[i]  = (c == 1);
                        in_load[i]    = (c == 1) || (c == 2) || (c == 6);
                        in_store[i]   = (c == 3) || (c == 6);
                        in_nonspec[i] = (c == 4) || (c == 6) || (c == 7);
                        in_nop[i]     = (c == 5) || (c == 6) || (c == 7);
                        in_tag[i*TAG_W +: TAG_W] = TAG_W'(code + i);
                    end
                    // Reference model
                    x_iq = '0; x_ld = '0; x_st = '0; x_ns = '0; x_nop = '0; x_cr = '0;
                    x_tag = '0; x_blk = 1'b0; stop = 1'b0; avail = fr;
                    for (int i = 0; i < N; i++) begin
                        if (i < grp && !stop) begin
                            if (in_squash[i]) begin
                                e_sq++;
                            end else if (avail == 0) begin
                                x_blk = 1'b1; stop = 1'b1; e_full++;
                            end else if (in_load[i]) begin
                                x_iq[i] = 1'b1; x_ld[i] = 1'b1; avail--; e_ld++; e_disp++;
                            end else if (in_store[i]) begin
                                x_iq[i] = 1'b1; x_st[i] = 1'b1; avail--; e_st++; e_disp++;
                            end else if (in_nonspec[i]) begin
                                x_ns[i] = 1'b1; x_cr[i] = 1'b1; avail--; e_ns++;
                            end else if (in_nop[i]) begin
                                x_nop[i] = 1'b1; x_cr[i] = 1'b1;
                            end else begin
                                x_iq[i] = 1'b1; avail--; e_disp++;
                            end
                            if (x_iq[i] || x_ns[i] || x_nop[i])
                                x_tag[i*TAG_W +: TAG_W] = in_tag[i*TAG_W +: TAG_W];
                        end
                    end
                    #2;
                    chk("R9 R10 R8", "iq_wr", 64'(iq_wr), 64'(x_iq));
                    chk("R4 R8", "lsq_ld_wr", 64'(lsq_ld_wr), 64'(x_ld));
                    chk("R5 R8", "lsq_st_wr", 64'(lsq_st_wr), 64'(x_st));
                    chk("R6 R2", "ns_wr", 64'(ns_wr), 64'(x_ns));
                    chk("R7", "nop_done", 64'(nop_done), 64'(x_nop));
                    chk("R6 R7", "commit_rdy", 64'(commit_rdy), 64'(x_cr));
                    chk("R3", "block_req", 64'(block_req), 64'(x_blk));
                    chk("R3", "rename_stall", 64'(rename_stall), 64'(x_blk));
                    chk("R12", "out_tag", 64'(out_tag), 64'(x_tag));
                    @(posedge clk);
                    #1;
                    chk_counters("R2 R3 R11");
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule